// File: doc/BRIEF.md
# Serial Receive Queue with Flow Control

This block is the receive side of an asynchronous serial port. It picks a line source (the external receive pin, or the local transmitter output when loopback is selected), optionally inverts it, samples it with a fixed clock divider, strips the start, parity and stop bits, and pushes each character into a 128-byte queue. The host takes characters from the queue through a read strobe; the head byte is always visible on the read data port.

Around the queue the block produces the conditions an interrupt controller and the far end need. It raises the request-to-send output to throttle the sender when the queue fills past a programmable level, and it raises a separate fill flag at another level. It reports a receive timeout when data has sat unread with no line activity for a programmable number of character times. It pulses overflow, parity error, framing error and break indications.

Top module: `serial_rx_queue`

## Requirements
- R1: A character starts with a low start bit and carries its data bits least significant first; `cfg_len` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits, and the stored byte is right-aligned with upper bits zero.
- R2: With `cfg_par_en` set, one parity bit follows the data; `cfg_par_odd`=1 means data plus parity hold an odd number of ones, 0 an even number; a mismatch gives a one-cycle `par_err_pulse` and the byte is still stored.
- R3: A character whose stop bit samples low, but is not entirely low, gives a one-cycle `frm_err_pulse` and the byte is still stored.
- R4: A frame that is low from the start bit through the stop position gives a one-cycle `brk_pulse`, stores nothing, and the receiver waits for the line to go high before hunting for a new start bit.
- R5: A low pulse that has ended by the middle of the start bit is ignored; nothing is stored.
- R6: The queue holds 128 bytes in arrival order with the head on `rd_data`; a read strobe on an empty queue has no effect; a byte arriving while 128 are held is dropped with a one-cycle `ovf_pulse` and the count stays 128.
- R7: `rts_out` is high exactly when `cfg_rts_en` is set and the count exceeds `cfg_rts_thr`.
- R8: `full_flag` is high exactly when the count exceeds `cfg_full_thr`.
- R9: With `cfg_tout_en` set and the queue not empty, `tout_flag` rises (`cfg_tout_thr`+1) character times (10 bit periods each) after the last push or read, and drops on the next push, read, or when the queue is empty.
- R10: With `cfg_invert` set, the selected line is inverted before sampling.
- R11: With `cfg_loopback` set, the receiver takes `tx_loop` and ignores `rxd_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd_pin | input | 1 | External receive line |
| tx_loop | input | 1 | Local transmit output for loopback |
| cfg_invert | input | 1 | Invert the selected line |
| cfg_loopback | input | 1 | Receive from `tx_loop` |
| cfg_len | input | 2 | Data bits: 0..3 gives 5..8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd, 0 even parity |
| cfg_rts_en | input | 1 | Enable request-to-send throttling |
| cfg_rts_thr | input | 7 | Count above which `rts_out` rises |
| cfg_full_thr | input | 7 | Count above which `full_flag` rises |
| cfg_tout_en | input | 1 | Enable idle timeout |
| cfg_tout_thr | input | 7 | Idle timeout in character times, minus one |
| rd_en | input | 1 | Remove head byte |
| rd_data | output | 8 | Head byte of the queue |
| fifo_cnt | output | 8 | Bytes held, 0..128 |
| fifo_empty | output | 1 | Queue empty |
| rts_out | output | 1 | High asks the sender to stop |
| full_flag | output | 1 | Fill above full threshold |
| ovf_pulse | output | 1 | Byte dropped on a full queue |
| tout_flag | output | 1 | Receive idle timeout |
| par_err_pulse | output | 1 | Parity mismatch |
| frm_err_pulse | output | 1 | Stop bit low |
| brk_pulse | output | 1 | Break seen |

## Verification
A slipped bit counter or a wrong sample point shows as a shifted or truncated byte on `rd_data` one bit period after the stop bit, and a wrong parity or break decision shows as a missing or extra pulse in that same cycle. A queue pointer or count fault appears on `fifo_cnt` and the fill-driven outputs in the cycle after the push or read, while a dropped or reordered entry only appears when the queue is drained. A timer fault is visible only after a full threshold window, so the timeout edge is checked a few cycles on either side of its expected position.

// File: rtl/srq_pkg.sv
// Shared types for the serial receive queue.
// Assumes nothing beyond the states listed here.
package srq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;
endpackage

// File: rtl/srq_deframer.sv
// Character deframer: synchronises the line, checks the start bit at its
// middle, samples data/parity/stop at bit centres, and reports the byte with
// its error status. Assumes DIV clocks per bit and DIV >= 4.
module srq_deframer
    import srq_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       char_valid,
    output logic [7:0] char_data,
    output logic       par_err,
    output logic       frm_err,
    output logic       brk
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(DIV / 2 - 1);

    rx_state_t     state;
    logic [1:0]    sync;
    logic          line;
    logic [CW-1:0] tick;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          par_bit;
    logic          all_zero;
    logic [3:0]    nbits;
    logic [7:0]    data_al;

    assign line    = sync[1];
    assign nbits   = 4'd5 + {2'b00, cfg_len};
    assign data_al = shreg >> (4'd8 - nbits);

    // Two-flop synchroniser on the incoming line
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], line_in};
    end

    // Frame state machine with bit-centre sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tick       <= '0;
            bitn       <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            all_zero   <= 1'b0;
            char_valid <= 1'b0;
            char_data  <= '0;
            par_err    <= 1'b0;
            frm_err    <= 1'b0;
            brk        <= 1'b0;
        end else begin
            char_valid <= 1'b0;
            par_err    <= 1'b0;
            frm_err    <= 1'b0;
            brk        <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!line) begin
                        state    <= ST_START;
                        tick     <= '0;
                        all_zero <= 1'b1;
                    end
                end
                ST_START: begin
                    if (tick == HALF_LAST) begin
                        tick <= '0;
                        bitn <= '0;
                        state <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (tick == LAST) begin
                        tick     <= '0;
                        shreg    <= {line, shreg[7:1]};
                        all_zero <= all_zero & ~line;
                        if ({1'b0, bitn} == nbits - 4'd1)
                            state <= cfg_par_en ? ST_PAR : ST_STOP;
                        else
                            bitn <= bitn + 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (tick == LAST) begin
                        tick     <= '0;
                        par_bit  <= line;
                        all_zero <= all_zero & ~line;
                        state    <= ST_STOP;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick == LAST) begin
                        tick <= '0;
                        if (all_zero && !line) begin
                            brk   <= 1'b1;
                            state <= ST_HOLD;
                        end else begin
                            char_valid <= 1'b1;
                            char_data  <= data_al;
                            frm_err    <= ~line;
                            par_err    <= cfg_par_en & ((^data_al ^ par_bit) != cfg_par_odd);
                            state      <= line ? ST_IDLE : ST_HOLD;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: begin
                    if (line) state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick == HALF_LAST && line) |=> (state == ST_IDLE)); // R5
    AST_BRK_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !char_valid); // R4
endmodule

// File: rtl/srq_fifo.sv
// Byte queue with show-ahead read port and occupancy count. A push on a full
// queue is dropped and flagged. Assumes DEPTH is a power of two.
module srq_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH):0]     cnt,
    output logic                       empty,
    output logic                       full,
    output logic                       ovf
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNTW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign ovf     = push & full;
    assign rd_data = mem[rptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(cnt)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH)); // R6
endmodule

// File: rtl/srq_idle_timer.sv
// Receive idle timer: counts whole character times while data waits in the
// queue, and raises a sticky flag once the threshold is passed. Any push,
// read, empty queue or disable restarts it.
module srq_idle_timer #(
    parameter int CHAR_CLKS = 160,
    parameter int THR_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic             activity,
    input  logic             empty,
    output logic             flag
);
    localparam int PW = $clog2(CHAR_CLKS);
    localparam logic [PW-1:0] PLAST = PW'(CHAR_CLKS - 1);

    logic [PW-1:0]    pc;
    logic [THR_W-1:0] units;

    // Character-time prescaler, unit counter and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n || activity || empty || !en) begin
            pc    <= '0;
            units <= '0;
            flag  <= 1'b0;
        end else if (pc == PLAST) begin
            pc <= '0;
            if (units == thr) flag  <= 1'b1;
            else              units <= units + 1'b1;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    AST_TOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !empty); // R9
endmodule

// File: rtl/serial_rx_queue.sv
// Serial receive queue top: selects and conditions the line, deframes
// characters, queues them, and derives flow control and interrupt conditions.
// Assumes configuration changes only while the line is idle.
module serial_rx_queue #(
    parameter int DIV   = 16,
    parameter int DEPTH = 128,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_pin,
    input  logic             tx_loop,
    input  logic             cfg_invert,
    input  logic             cfg_loopback,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_rts_en,
    input  logic [THR_W-1:0] cfg_rts_thr,
    input  logic [THR_W-1:0] cfg_full_thr,
    input  logic             cfg_tout_en,
    input  logic [THR_W-1:0] cfg_tout_thr,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [$clog2(DEPTH):0] fifo_cnt,
    output logic             fifo_empty,
    output logic             rts_out,
    output logic             full_flag,
    output logic             ovf_pulse,
    output logic             tout_flag,
    output logic             par_err_pulse,
    output logic             frm_err_pulse,
    output logic             brk_pulse
);
    localparam int CNTW      = $clog2(DEPTH) + 1;
    localparam int CHAR_CLKS = DIV * 10;

    logic       line_sel;
    logic       ch_valid;
    logic [7:0] ch_data;
    logic       q_full;
    logic       rd_take;

    // Line source selection and polarity
    assign line_sel = (cfg_loopback ? tx_loop : rxd_pin) ^ cfg_invert;
    assign rd_take  = rd_en & ~fifo_empty;

    srq_deframer #(.DIV(DIV)) u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_sel),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .char_valid (ch_valid),
        .char_data  (ch_data),
        .par_err    (par_err_pulse),
        .frm_err    (frm_err_pulse),
        .brk        (brk_pulse)
    );

    srq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ch_valid),
        .push_data(ch_data),
        .pop      (rd_en),
        .rd_data  (rd_data),
        .cnt      (fifo_cnt),
        .empty    (fifo_empty),
        .full     (q_full),
        .ovf      (ovf_pulse)
    );

    srq_idle_timer #(.CHAR_CLKS(CHAR_CLKS), .THR_W(THR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_tout_en),
        .thr     (cfg_tout_thr),
        .activity(ch_valid | rd_take),
        .empty   (fifo_empty),
        .flag    (tout_flag)
    );

    // Fill-level comparisons for flow control and the fill flag
    assign rts_out   = cfg_rts_en & (fifo_cnt > CNTW'(cfg_rts_thr));
    assign full_flag = (fifo_cnt > CNTW'(cfg_full_thr));

    AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (q_full && fifo_cnt == CNTW'(DEPTH))); // R6
endmodule

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
    localparam int DIV  = 16;
    localparam int CHAR = DIV * 10;
    // {len[1:0], par_en, par_odd, bad_par, bad_stop, exp_pe, exp_fe, 4'h0, data[7:0]}
    localparam logic [19:0] VEC [8] = '{
        20'hC00A5, 20'hE003C, 20'hF003C, 20'hEA081,
        20'h00016, 20'h7002A, 20'h85055, 20'hC0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv = 1'b1;
    logic use_loop = 1'b0;
    logic cfg_invert = 1'b0, cfg_loopback = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_rts_en = 1'b0, cfg_tout_en = 1'b0;
    logic [6:0] cfg_rts_thr = '0, cfg_full_thr = '0, cfg_tout_thr = '0;
    logic rd_en = 1'b0;
    logic [7:0] rd_data, fifo_cnt;
    logic fifo_empty, rts_out, full_flag, ovf_pulse, tout_flag;
    logic par_err_pulse, frm_err_pulse, brk_pulse;
    logic rxd_pin, tx_loop;
    int nchk = 0, nfail = 0, cyc = 0;
    int n_pe = 0, n_fe = 0, n_brk = 0, n_ovf = 0;

    assign rxd_pin = use_loop ? 1'b0 : drv;
    assign tx_loop = use_loop ? drv : 1'b1;

    always #5 clk = ~clk;

    serial_rx_queue u_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .rxd_pin(rxd_pin), .tx_loop(tx_loop),
        .cfg_invert(cfg_invert), .cfg_loopback(cfg_loopback), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_rts_en(cfg_rts_en),
        .cfg_rts_thr(cfg_rts_thr), .cfg_full_thr(cfg_full_thr), .cfg_tout_en(cfg_tout_en),
        .cfg_tout_thr(cfg_tout_thr), .rd_en(rd_en), .rd_data(rd_data), .fifo_cnt(fifo_cnt),
        .fifo_empty(fifo_empty), .rts_out(rts_out), .full_flag(full_flag),
        .ovf_pulse(ovf_pulse), .tout_flag(tout_flag), .par_err_pulse(par_err_pulse),
        .frm_err_pulse(frm_err_pulse), .brk_pulse(brk_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (par_err_pulse) n_pe  <= n_pe + 1;
        if (frm_err_pulse) n_fe  <= n_fe + 1;
        if (brk_pulse)     n_brk <= n_brk + 1;
        if (ovf_pulse)     n_ovf <= n_ovf + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bits(input logic v, input int n);
        drv = v;
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic pe, input logic po,
                        input logic badp, input logic bads, input logic inv);
        logic p;
        p = po;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        bits(1'b0 ^ inv, 1);
        for (int i = 0; i < nb; i++) bits(d[i] ^ inv, 1);
        if (pe) bits((p ^ badp) ^ inv, 1);
        bits(~bads ^ inv, 1);
        bits(1'b1 ^ inv, 1);
    endtask

    task automatic pop;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        wait (cyc == 150000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int pe0, fe0, b0, o0, bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R6 reset count", fifo_cnt, 0);
        chk("R6 reset empty", fifo_empty, 1);
        chk("R7 reset rts", rts_out, 0);
        chk("R8 reset full", full_flag, 0);
        chk("R9 reset tout", tout_flag, 0);
        cfg_full_thr = 7'd127;

        // table of characters
        foreach (VEC[k]) begin
            logic [7:0] m;
            cfg_len = VEC[k][19:18];
            cfg_par_en = VEC[k][17];
            cfg_par_odd = VEC[k][16];
            m = 8'hFF >> (3 - VEC[k][19:18]);
            pe0 = n_pe; fe0 = n_fe;
            send(VEC[k][7:0], 5 + int'(VEC[k][19:18]), VEC[k][17], VEC[k][16],
                 VEC[k][15], VEC[k][14], 1'b0);
            chk("R1 count after char", fifo_cnt, 1);
            chk("R1 data", rd_data, int'(VEC[k][7:0] & m));
            chk("R2 parity error", n_pe - pe0, int'(VEC[k][13]));
            chk("R3 frame error", n_fe - fe0, int'(VEC[k][12]));
            pop();
        end
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // empty read has no effect
        pop();
        chk("R6 read on empty", fifo_cnt, 0);

        // glitch shorter than half a bit
        drv = 1'b0;
        repeat (DIV / 2 - 3) @(negedge clk);
        bits(1'b1, 2);
        chk("R5 glitch stores nothing", fifo_cnt, 0);

        // break
        b0 = n_brk; fe0 = n_fe;
        bits(1'b0, 14);
        bits(1'b1, 2);
        chk("R4 break pulse", n_brk - b0, 1);
        chk("R4 break stores nothing", fifo_cnt, 0);
        chk("R4 break no frame error", n_fe - fe0, 0);
        send(8'h6E, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 char after break", rd_data, 8'h6E);
        pop();

        // inverted line
        cfg_invert = 1'b1; drv = 1'b0;
        repeat (2) @(negedge clk);
        send(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 inverted data", rd_data, 8'hC3);
        chk("R10 inverted count", fifo_cnt, 1);
        pop();
        cfg_invert = 1'b0; drv = 1'b1;
        repeat (2) @(negedge clk);

        // loopback with the pin held low
        cfg_loopback = 1'b1; use_loop = 1'b1;
        repeat (2) @(negedge clk);
        b0 = n_brk;
        send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 loopback data", rd_data, 8'h5A);
        chk("R11 pin ignored", n_brk - b0, 0);
        pop();
        cfg_loopback = 1'b0; use_loop = 1'b0;
        repeat (2) @(negedge clk);

        // fill, thresholds, overflow
        cfg_rts_en = 1'b1; cfg_rts_thr = 7'd99; cfg_full_thr = 7'd49;
        cfg_tout_en = 1'b1; cfg_tout_thr = 7'd2;
        for (int i = 0; i < 128; i++) begin
            send(8'(i), 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            if (i == 48) chk("R8 full at 49", full_flag, 0);
            if (i == 49) chk("R8 full at 50", full_flag, 1);
            if (i == 98) chk("R7 rts at 99", rts_out, 0);
            if (i == 99) chk("R7 rts at 100", rts_out, 1);
        end
        chk("R6 count 128", fifo_cnt, 128);
        o0 = n_ovf;
        send(8'hEE, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 overflow pulse", n_ovf - o0, 1);
        chk("R6 count stays 128", fifo_cnt, 128);
        cfg_rts_en = 1'b0;
        @(negedge clk);
        chk("R7 rts disabled", rts_out, 0);

        // idle timeout after a read
        chk("R6 head is first", rd_data, 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (3 * CHAR - 3) @(negedge clk);
        chk("R9 timeout not yet", tout_flag, 0);
        repeat (6) @(negedge clk);
        chk("R9 timeout raised", tout_flag, 1);
        pop();
        chk("R9 timeout cleared by read", tout_flag, 0);

        // drain and order
        bad = 0;
        for (int i = 2; i < 128; i++) begin
            if (rd_data != 8'(i)) bad++;
            pop();
        end
        chk("R6 order on drain", bad, 0);
        chk("R6 empty after drain", fifo_empty, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule